// File: doc/BRIEF.md
# Pairwise-Order LRU State Tracker

This block holds the recency order of the ways in every set of a set-associative cache. Each set stores one bit for each unordered pair of ways, and that bit says which way of the pair was used more recently. With the default four ways, each set has six bits. A full ordering of the ways is therefore kept exactly, with no approximation.

The cache controller reports every hit or line fill as an access to one (set, way). The tracker then rewrites that set's pair bits so that the accessed way becomes the most recent way. A separate query port returns, without a clock delay, the least-recently-used way of any set as the replacement victim. It also raises a flag when the stored bits do not encode a consistent order.

A software port reads any set's bits without a clock delay and writes them on the next edge. Only bit patterns that encode a full ordering give a defined victim.

Top module: `lru_pair_tracker`

## Requirements
- R1: On an active-low power-on reset, the pair bits of every set become all zero.
- R2: The all-zero pattern is a legal ordering. The query port reports way 0 as the victim with the illegal flag low.
- R3: Bit layout for four ways, bit 0 to bit 5: pairs (0,1), (0,2), (0,3), (1,2), (1,3), (2,3). A 1 means the lower-numbered way of the pair was used more recently. An access to way w sets every bit (w,j) with j>w to 1 and clears every bit (i,w) with i<w. The set's other bits keep their values.
- R4: `q_victim` is the way that every one of its pair bits marks as older than its partner. It reflects the stored state of `q_set` without a clock delay.
- R5: When no way, or more than one way, qualifies as the victim, `q_illegal` is 1 and `q_victim` reads 0.
- R6: A software write stores `sw_wdata` into set `sw_set` at the next clock edge. `sw_rdata` always shows the stored bits of `sw_set` without a clock delay.
- R7: A software write and an access to the same set in the same cycle leave exactly the written value.
- R8: A software write and an access to different sets in the same cycle both take effect.
- R9: An access changes no set other than the one it addresses.
- R10: When `acc_valid` is low, the access inputs change no state.
- R11: A sequence of accesses gives true least-recently-used replacement. After ways 2, 0, 1, 3 are used in turn, the victim is way 2. Using way 2 again then makes way 0 the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| acc_valid | input | 1 | An access (hit or fill) happens this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way used by the access |
| sw_we | input | 1 | Software write strobe |
| sw_set | input | SET_W | Set index for software read and write |
| sw_wdata | input | PAIRS | Pair bits to write |
| sw_rdata | output | PAIRS | Stored pair bits of `sw_set` |
| q_set | input | SET_W | Set index for the victim query |
| q_victim | output | WAY_W | Least-recently-used way of `q_set` |
| q_illegal | output | 1 | The bits of `q_set` encode no single victim |

## Verification
The bench builds the tracker with its default values: 128 sets and four ways, so six pair bits per set. This keeps the documented bit layout fixed, so the expected patterns can be worked out by hand. It also puts both end sets, 0 and 127, within reach for the reset checks. With four ways, a walk of nine accesses through one set reaches every way as both the most-recent and the victim position. A cyclic pattern written by software reaches the illegal-flag path.

// File: rtl/lru_pair_pkg.sv
package lru_pair_pkg;

   // number of unordered way pairs
   function automatic int pair_count(input int ways);
      return (ways * (ways - 1)) / 2;
   endfunction

   // bit position of pair (lo,hi), lo < hi, rows ordered by lo
   function automatic int pair_index(input int lo, input int hi, input int ways);
      return lo * ways - (lo * (lo + 1)) / 2 + (hi - lo - 1);
   endfunction

endpackage

// File: rtl/lru_pair_update.sv
module lru_pair_update
   import lru_pair_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   localparam int WAY_W = $clog2(NUM_WAYS),
   localparam int PAIRS = pair_count(NUM_WAYS)
) (
   input  logic [PAIRS-1:0] cur_bits,
   input  logic [WAY_W-1:0] used_way,
   output logic [PAIRS-1:0] nxt_bits
);

   for (genvar lo = 0; lo < NUM_WAYS; lo++) begin : g_lo
      for (genvar hi = lo + 1; hi < NUM_WAYS; hi++) begin : g_hi
         localparam int IDX = pair_index(lo, hi, NUM_WAYS);
         always_comb begin
            if (used_way == WAY_W'(lo))
               nxt_bits[IDX] = 1'b1;
            else if (used_way == WAY_W'(hi))
               nxt_bits[IDX] = 1'b0;
            else
               nxt_bits[IDX] = cur_bits[IDX];
         end
      end
   end

endmodule

// File: rtl/lru_pair_victim.sv
module lru_pair_victim
   import lru_pair_pkg::*;
#(
   parameter int NUM_WAYS = 4,
   localparam int WAY_W = $clog2(NUM_WAYS),
   localparam int PAIRS = pair_count(NUM_WAYS)
) (
   input  logic [PAIRS-1:0]    cur_bits,
   output logic [WAY_W-1:0]    victim,
   output logic                illegal
);

   logic [NUM_WAYS-1:0] cand;

   for (genvar v = 0; v < NUM_WAYS; v++) begin : g_way
      logic [NUM_WAYS-1:0] older;
      for (genvar u = 0; u < NUM_WAYS; u++) begin : g_peer
         if (u == v) begin : g_self
            assign older[u] = 1'b1;
         end else if (v < u) begin : g_below
            assign older[u] = ~cur_bits[pair_index(v, u, NUM_WAYS)];
         end else begin : g_above
            assign older[u] = cur_bits[pair_index(u, v, NUM_WAYS)];
         end
      end
      assign cand[v] = &older;
   end

   always_comb begin
      illegal = ($countones(cand) != 1);
      victim  = '0;
      if (!illegal) begin
         for (int k = 0; k < NUM_WAYS; k++) begin
            if (cand[k]) victim = WAY_W'(k);
         end
      end
   end

endmodule

// File: rtl/lru_pair_tracker.sv
module lru_pair_tracker
   import lru_pair_pkg::*;
#(
   parameter int NUM_SETS = 128,
   parameter int NUM_WAYS = 4,
   localparam int SET_W = $clog2(NUM_SETS),
   localparam int WAY_W = $clog2(NUM_WAYS),
   localparam int PAIRS = pair_count(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [SET_W-1:0] acc_set,
   input  logic [WAY_W-1:0] acc_way,
   input  logic             sw_we,
   input  logic [SET_W-1:0] sw_set,
   input  logic [PAIRS-1:0] sw_wdata,
   output logic [PAIRS-1:0] sw_rdata,
   input  logic [SET_W-1:0] q_set,
   output logic [WAY_W-1:0] q_victim,
   output logic             q_illegal
);

   if (NUM_WAYS < 2 || (1 << WAY_W) != NUM_WAYS) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two of at least 2");
   end
   if (NUM_SETS < 2 || (1 << SET_W) != NUM_SETS) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end

   logic [PAIRS-1:0] state_q [NUM_SETS];
   logic [PAIRS-1:0] acc_cur;
   logic [PAIRS-1:0] acc_nxt;
   logic             acc_take;

   assign acc_cur  = state_q[acc_set];
   assign acc_take = acc_valid && !(sw_we && (sw_set == acc_set));

   lru_pair_update #(.NUM_WAYS(NUM_WAYS)) u_upd (
      .cur_bits (acc_cur),
      .used_way (acc_way),
      .nxt_bits (acc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) state_q[s] <= '0;
      end else begin
         if (acc_take) state_q[acc_set] <= acc_nxt;
         if (sw_we)    state_q[sw_set]  <= sw_wdata;
      end
   end

   assign sw_rdata = state_q[sw_set];

   lru_pair_victim #(.NUM_WAYS(NUM_WAYS)) u_vic (
      .cur_bits (state_q[q_set]),
      .victim   (q_victim),
      .illegal  (q_illegal)
   );

endmodule

// File: rtl/lru_pair_tracker_chk.sv
module lru_pair_tracker_chk #(
   parameter int SET_W = 7,
   parameter int WAY_W = 2,
   parameter int PAIRS = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic [SET_W-1:0] acc_set,
   input logic [WAY_W-1:0] acc_way,
   input logic             sw_we,
   input logic [SET_W-1:0] sw_set,
   input logic [PAIRS-1:0] sw_wdata,
   input logic [PAIRS-1:0] sw_rdata,
   input logic [SET_W-1:0] q_set,
   input logic [WAY_W-1:0] q_victim,
   input logic             q_illegal
);

   // R6
   sw_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sw_we) && (sw_set == $past(sw_set)) |-> sw_rdata == $past(sw_wdata));

   // R9
   untouched_set_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!sw_we && !(acc_valid && acc_set == sw_set)) && (sw_set == $past(sw_set))
      |-> $stable(sw_rdata));

   // R11
   mru_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_valid && !(sw_we && sw_set == acc_set)) && (q_set == $past(acc_set)) && !q_illegal
      |-> q_victim != $past(acc_way));

   // R3
   legal_kept_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_valid && !sw_we && q_set == acc_set && !q_illegal) && (q_set == $past(q_set))
      |-> !q_illegal);

   // R10
   idle_victim_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!acc_valid && !sw_we) && (q_set == $past(q_set)) |-> $stable(q_victim) && $stable(q_illegal));

   // R5
   illegal_victim_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_illegal |-> q_victim == '0);

endmodule

bind lru_pair_tracker lru_pair_tracker_chk #(
   .SET_W (SET_W),
   .WAY_W (WAY_W),
   .PAIRS (PAIRS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_set   (acc_set),
   .acc_way   (acc_way),
   .sw_we     (sw_we),
   .sw_set    (sw_set),
   .sw_wdata  (sw_wdata),
   .sw_rdata  (sw_rdata),
   .q_set     (q_set),
   .q_victim  (q_victim),
   .q_illegal (q_illegal)
);

// File: tb/sim_lru_pair_tracker.sv
module sim_lru_pair_tracker;

   localparam int SET_W = 7;
   localparam int WAY_W = 2;
   localparam int PAIRS = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_valid = 1'b0;
   logic [SET_W-1:0] acc_set = '0;
   logic [WAY_W-1:0] acc_way = '0;
   logic             sw_we = 1'b0;
   logic [SET_W-1:0] sw_set = '0;
   logic [PAIRS-1:0] sw_wdata = '0;
   logic [PAIRS-1:0] sw_rdata;
   logic [SET_W-1:0] q_set = '0;
   logic [WAY_W-1:0] q_victim;
   logic             q_illegal;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   lru_pair_tracker u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
      .acc_way(acc_way), .sw_we(sw_we), .sw_set(sw_set), .sw_wdata(sw_wdata),
      .sw_rdata(sw_rdata), .q_set(q_set), .q_victim(q_victim), .q_illegal(q_illegal)
   );

   // {way[1:0], expected bits[5:0], expected victim[1:0]} applied to one set from reset
   localparam logic [9:0] WALK [9] = '{
      {2'd2, 6'h20, 2'd0},
      {2'd0, 6'h27, 2'd1},
      {2'd1, 6'h3E, 2'd3},
      {2'd3, 6'h0A, 2'd2},
      {2'd2, 6'h20, 2'd0},
      {2'd0, 6'h27, 2'd1},
      {2'd0, 6'h27, 2'd1},
      {2'd3, 6'h03, 2'd1},
      {2'd1, 6'h1A, 2'd2}
   };

   task automatic check(input string req, input int got, input int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic peek(input int s);
      sw_set = SET_W'(s);
      q_set  = SET_W'(s);
      #1;
   endtask

   task automatic cycle(input bit a_v, input int a_s, input int a_w,
                        input bit w_e, input int w_s, input int w_d);
      @(negedge clk);
      acc_valid = a_v; acc_set = SET_W'(a_s); acc_way = WAY_W'(a_w);
      sw_we = w_e; sw_set = SET_W'(w_s); sw_wdata = PAIRS'(w_d);
      @(posedge clk);
      #1;
      acc_valid = 1'b0;
      sw_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 R2: reset state at both end sets
      peek(0);
      check("R1 set0 bits", sw_rdata, 0);
      check("R2 set0 victim", q_victim, 0);
      check("R2 set0 legal", q_illegal, 0);
      peek(127);
      check("R1 set127 bits", sw_rdata, 0);
      check("R2 set127 victim", q_victim, 0);

      // R3 R4 R11: table walk on set 5
      foreach (WALK[i]) begin
         cycle(1'b1, 5, WALK[i][9:8], 1'b0, 0, 0);
         peek(5);
         check($sformatf("R3 walk %0d bits", i), sw_rdata, WALK[i][7:2]);
         check($sformatf("R4 walk %0d victim", i), q_victim, WALK[i][1:0]);
         check($sformatf("R11 walk %0d legal", i), q_illegal, 0);
      end

      // R6: value visible only after the edge
      @(negedge clk);
      sw_we = 1'b1; sw_set = 7'd20; sw_wdata = 6'h3F; q_set = 7'd20;
      #1;
      check("R6 before edge", sw_rdata, 0);
      @(posedge clk);
      #1 sw_we = 1'b0;
      peek(20);
      check("R6 after edge", sw_rdata, 'h3F);
      check("R4 order 0>1>2>3 victim", q_victim, 3);

      // R5: cyclic pattern 0>1>2>0 with way 3 newest
      cycle(1'b0, 0, 0, 1'b1, 21, 'h09);
      peek(21);
      check("R5 illegal flag", q_illegal, 1);
      check("R5 victim zero", q_victim, 0);

      // R7: write wins over access to the same set
      cycle(1'b1, 10, 3, 1'b1, 10, 'h3F);
      peek(10);
      check("R7 write wins", sw_rdata, 'h3F);

      // R8: different sets both take effect
      cycle(1'b1, 12, 2, 1'b1, 11, 'h3F);
      peek(11);
      check("R8 written set", sw_rdata, 'h3F);
      peek(12);
      check("R8 accessed set", sw_rdata, 'h20);

      // R9: set 5 untouched by later traffic
      peek(5);
      check("R9 set5 kept", sw_rdata, 'h1A);

      // R10: invalid access ignored
      @(negedge clk);
      acc_valid = 1'b0; acc_set = 7'd12; acc_way = 2'd0;
      @(posedge clk);
      #1;
      peek(12);
      check("R10 invalid access", sw_rdata, 'h20);
      check("R10 victim kept", q_victim, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule